// File: doc/BRIEF.md
# Flash Sequencer Status and Write-Gate Register

This block is a single byte-wide register on the processor bus that watches the ready/busy line of an embedded flash array's program/erase sequencer. Each completion of a sequencer run, which shows as a low-to-high change on that line, sets a sticky done flag. When the interrupt enable is also set, the done flag raises an interrupt request to the CPU. Software acknowledges the completion by writing 0 to the flag.

The same register holds a write-enable bit. That bit gates every CPU write strobe aimed at the flash array, so data and command writes reach the array only after software has opened the gate. Reads from the flash are never gated. A read-only bit shows the synchronized ready/busy level, and the four low bits always read as zero.

The ready/busy line crosses into the bus clock domain through a synchronizer chain. Reset loads that chain and the edge detector with the ready level, so leaving reset can never look like a completion.

Top module: `flash_stat_reg`

## Requirements
- R1: After a synchronous reset, bit 7, bit 6 and bit 5 of the status byte read 0. The interrupt request and the gated flash write strobe are also 0.
- R2: Bit 7 (interrupt enable) takes the value written to it by a bus write at the register address (default 0x7C0). The new value is visible on the status byte from the clock edge that performs the write.
- R3: A low-to-high change on the ready/busy input sets bit 6 (done flag) at the third rising clock edge after the change. After the second edge the flag still reads 0.
- R4: A register write with bit 6 = 0 clears the done flag. A write with bit 6 = 1 leaves the flag unchanged, so a flag at 0 stays 0.
- R5: If a completion edge and a write that clears the flag take effect on the same clock edge, the flag ends at 1.
- R6: The interrupt request is 1 exactly when bit 7 and bit 6 of the status byte are both 1.
- R7: Bit 5 (write enable) takes the written value. The flash write strobe output equals the CPU flash write strobe ANDed with bit 5.
- R8: Bit 4 shows the ready/busy input after two rising clock edges, with 1 meaning ready. Writes to bit 4 have no effect.
- R9: Bits 3 to 0 of the status byte always read 0.
- R10: Writes to any address other than the register address change no register bit.
- R11: A high-to-low change on the ready/busy input does not set the done flag. Leaving reset with the line held low does not set it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | CPU byte address |
| bus_wr | input | 1 | CPU write strobe for register space |
| bus_wdata | input | 8 | CPU write data |
| status_o | output | 8 | Status byte: enable, done flag, write enable, ready, four zeros |
| seq_rdy_i | input | 1 | Sequencer ready/busy line, asynchronous, 1 = ready |
| cpu_flash_wr_i | input | 1 | CPU write strobe decoded for the flash address range |
| flash_wr_o | output | 1 | Flash write strobe after the write-enable gate |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The assertions assume that the ready/busy line holds each level long enough to pass the synchronizer. They also assume that bus writes are single-cycle strobes with the address and data stable for that cycle. The stimulus keeps every ready/busy phase at four clock cycles or longer and changes all inputs only on the falling clock edge. The same-edge case of R5 is produced by placing the clearing write exactly on the clock edge where the synchronized rising edge is detected.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_IE   = 7;
  localparam int unsigned BIT_DONE = 6;
  localparam int unsigned BIT_WEN  = 5;
  localparam int unsigned BIT_RDY  = 4;

  typedef struct packed {
    logic ie;
    logic done;
    logic wen;
  } ctl_t;
endpackage

// File: rtl/rdy_edge_det.sv
module rdy_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_i,
  output logic rdy_s_o,
  output logic rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // Reset holds the chain and the previous sample at "ready".
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rdy_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign rdy_s_o = sync_q[LAST];
  assign rise_o  = sync_q[LAST] & ~prev_q;

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/stat_ctrl_reg.sv
module stat_ctrl_reg
  import flash_stat_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_hit_i,
  input  logic wr_ie_i,
  input  logic wr_done_i,
  input  logic wr_wen_i,
  input  logic rise_i,
  output ctl_t ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      if (wr_hit_i) begin
        ctl_q.ie  <= wr_ie_i;
        ctl_q.wen <= wr_wen_i;
      end
      // Completion edge has priority over a software clear.
      if (rise_i)
        ctl_q.done <= 1'b1;
      else if (wr_hit_i && !wr_done_i)
        ctl_q.done <= 1'b0;
    end
  end

  assign ctl_o = ctl_q;

  // R3
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> ctl_q.done);
  // R4
  done_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.done) |-> $past(rise_i));
  // R4
  done_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q.done) |-> $past(wr_hit_i && !wr_done_i));
  // R10
  ie_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit_i |=> $stable(ctl_q.ie) && $stable(ctl_q.wen));
endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate (
  input  logic clk,
  input  logic rst,
  input  logic cpu_wr_i,
  input  logic en_i,
  output logic wr_o
);
  assign wr_o = cpu_wr_i & en_i;

  // R7
  gate_block_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> !wr_o);
endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
  import flash_stat_pkg::*;
#(
  parameter int unsigned     ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 16'h07C0,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        status_o,
  input  logic              seq_rdy_i,
  input  logic              cpu_flash_wr_i,
  output logic              flash_wr_o,
  output logic              irq_o
);
  logic wr_hit;
  logic rdy_s;
  logic rise;
  ctl_t ctl;
  logic unused_wdata;

  assign wr_hit       = bus_wr && (bus_addr == REG_ADDR);
  assign unused_wdata = &{1'b0, bus_wdata[3:0], bus_wdata[BIT_RDY]};

  rdy_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .rdy_i   (seq_rdy_i),
    .rdy_s_o (rdy_s),
    .rise_o  (rise)
  );

  stat_ctrl_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_hit_i  (wr_hit),
    .wr_ie_i   (bus_wdata[BIT_IE]),
    .wr_done_i (bus_wdata[BIT_DONE]),
    .wr_wen_i  (bus_wdata[BIT_WEN]),
    .rise_i    (rise),
    .ctl_o     (ctl)
  );

  flash_wr_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .cpu_wr_i (cpu_flash_wr_i),
    .en_i     (ctl.wen),
    .wr_o     (flash_wr_o)
  );

  always_comb begin
    status_o           = '0;
    status_o[BIT_IE]   = ctl.ie;
    status_o[BIT_DONE] = ctl.done;
    status_o[BIT_WEN]  = ctl.wen;
    status_o[BIT_RDY]  = rdy_s;
  end

  assign irq_o = ctl.ie & ctl.done;

  // R6
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> status_o[BIT_IE] && status_o[BIT_DONE]);
  // R11
  no_fall_set_chk: assert property (@(posedge clk) disable iff (rst)
    !rise && !status_o[BIT_DONE] |=> !status_o[BIT_DONE]);
endmodule

// File: tb/flash_stat_reg_test.sv
module flash_stat_reg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  status_o;
  logic        seq_rdy_i = 1'b1;
  logic        cpu_flash_wr_i = 1'b0;
  logic        flash_wr_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  flash_stat_reg uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .status_o(status_o), .seq_rdy_i(seq_rdy_i),
    .cpu_flash_wr_i(cpu_flash_wr_i), .flash_wr_o(flash_wr_o), .irq_o(irq_o)
  );

  // vector: addr[32:17], wdata[16:9], expected status[8:1], expected irq[0]
  // ready line held high, done flag 0 throughout
  localparam logic [32:0] VEC [0:6] = '{
    {16'h07C0, 8'hA0, 8'hB0, 1'b0},  // R2 R7 set ie and wen
    {16'h07C0, 8'h00, 8'h10, 1'b0},  // R2 R7 clear both
    {16'h07C0, 8'h80, 8'h90, 1'b0},  // R2 ie only
    {16'h07C1, 8'h20, 8'h90, 1'b0},  // R10 wrong address
    {16'h07C0, 8'h7F, 8'h30, 1'b0},  // R4 R8 R9 write 1s to done/rdy/low
    {16'h07C0, 8'h20, 8'h30, 1'b0},  // R7 wen only
    {16'h0000, 8'hFF, 8'h30, 1'b0}   // R10 wrong address
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic flash_probe(input logic exp, input string req);
    cpu_flash_wr_i = 1'b1;
    #1;
    check({7'd0, flash_wr_o}, {7'd0, exp}, req);
    cpu_flash_wr_i = 1'b0;
  endtask

  task automatic busy_pulse();
    seq_rdy_i = 1'b0;
    repeat (4) @(negedge clk);
    seq_rdy_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status_o & 8'hE0, 8'h00, "R1 status");
    check({6'd0, irq_o, flash_wr_o}, 8'h00, "R1 irq/fwr");
    flash_probe(1'b0, "R1 gate closed");
    // R9 low bits
    check(status_o & 8'h0F, 8'h00, "R9");

    foreach (VEC[i]) begin
      wr(VEC[i][32:17], VEC[i][16:9]);
      check(status_o, VEC[i][8:1], "R2/R4/R7/R8/R9/R10 vector");
      check({7'd0, irq_o}, {7'd0, VEC[i][0]}, "R6 vector irq");
      flash_probe(VEC[i][6], "R7 gate");
    end

    // R8 and R3 latency; R11 falling edge does not set
    wr(16'h07C0, 8'h00);
    seq_rdy_i = 1'b0;
    @(negedge clk);
    check(status_o & 8'h10, 8'h10, "R8 one edge");
    @(negedge clk);
    check(status_o & 8'h10, 8'h00, "R8 two edges");
    repeat (3) @(negedge clk);
    check(status_o & 8'h40, 8'h00, "R11 falling edge");
    seq_rdy_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(status_o & 8'h50, 8'h10, "R3 not yet");
    @(negedge clk);
    check(status_o & 8'h40, 8'h40, "R3 set");
    check({7'd0, irq_o}, 8'h00, "R6 ie off");

    // R4 write 1 keeps, then R6 irq with enable
    wr(16'h07C0, 8'hC0);
    check(status_o & 8'hC0, 8'hC0, "R4 write 1 keeps");
    check({7'd0, irq_o}, 8'h01, "R6 irq on");
    wr(16'h07C0, 8'h80);
    check(status_o & 8'hC0, 8'h80, "R4 clear");
    check({7'd0, irq_o}, 8'h00, "R6 irq off");

    // R5 simultaneous set and clear
    seq_rdy_i = 1'b0;
    repeat (4) @(negedge clk);
    seq_rdy_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(16'h07C0, 8'h80);
    check(status_o & 8'h40, 8'h40, "R5 set wins");
    wr(16'h07C0, 8'h00);
    check(status_o & 8'hC0, 8'h00, "R4 clear after R5");

    // R11 reset with line low
    seq_rdy_i = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(status_o & 8'h50, 8'h00, "R11 reset low");
    busy_pulse();
    check(status_o & 8'h40, 8'h40, "R3 after reset");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule